// File: doc/BRIEF.md
# Interrupt Status and Enable Pair with Class Summaries

This block collects single-cycle event pulses from the transmit and receive engines of a DMA-driven network controller and holds each one in a sticky status bit. Software clears a status bit by writing a one to its position. A zero leaves the bit alone. A second register holds one enable per source. It also holds one enable per class summary.

The nine sources fall into two classes. Routine completions form one class. Stall and error conditions form the other. Each class has its own summary status bit. That bit latches when any enabled source of the class fires. It is sticky and write-one-to-clear, just like a source bit. A single interrupt line is raised while an enabled summary is pending. The two registers share one write port and one read port. A one-bit address selects between them.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, both registers read 0 and `irq_o` is low.
- R2: Each source has a status bit at its own position. A pulse on `evt_i[k]` sets status bit k one clock later, whatever the enable bits hold. The positions are:
  - bit 0: transmit frame done
  - bit 1: transmit buffer unavailable
  - bit 2: receive frame done
  - bit 3: transmit stopped
  - bit 4: receive overflow
  - bit 5: transmit underflow
  - bit 6: receive buffer unavailable
  - bit 7: receive stopped
  - bit 8: fatal bus error
- R3: A write to the status register (`bus_addr`=0) clears every status bit written with 1. Bits written with 0 keep their value.
- R4: An event in the same cycle as a clear write to its bit leaves the bit set. The same holds for a summary bit.
- R5: Bits 0 to 2 form the normal class. Its summary is status bit 16. Bits 3 to 8 form the abnormal class. Its summary is status bit 15. A summary sets one clock after an event on a source of its class whose enable bit is 1. An event on a source whose enable is 0 does not set the summary.
- R6: A summary bit stays set after its sources are cleared. It clears only when a 1 is written to its own position.
- R7: The enable register (`bus_addr`=1) is written as a whole word and reads back its stored value. Bits 0 to 8 enable the sources at the same positions. Bit 16 enables the normal summary and bit 15 enables the abnormal summary. All other bits read 0.
- R8: `irq_o` is high exactly when (status bit 16 AND enable bit 16) OR (status bit 15 AND enable bit 15). It follows the registers with no further delay.
- R9: Writing ones to undefined status positions changes nothing, and those positions read 0.
- R10: Events of one class never set the other class's summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 9 | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Write target: 0 status, 1 enable |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 1 | Read select: 0 status, 1 enable |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that events are sampled on a clock edge as plain levels. They also assume that a write lasts exactly one cycle with its address stable. The interrupt-raise check further assumes that the enable register is not rewritten in the same cycle as the triggering event. Under these assumptions, set, hold and clear can be checked from one cycle to the next.

The stimulus changes inputs only just after a rising edge. It holds every write strobe for a single cycle. It never rewrites the enables while an event is being pulsed, so it stays within those assumptions. It sweeps every one of the 511 nonzero event patterns. It also tries every source with its enable both on and off, and it collides a clear write with an event on every bit.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

   // Target of a register access
   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_ENABLE = 1'b1
   } irqs_sel_e;

   // Number of summary classes; index 0 is normal, index 1 abnormal
   localparam int N_CLASS = 2;

endpackage

// File: rtl/irqs_src_bank.sv
module irqs_src_bank #(
   parameter int N_SRC = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] stat_o
);

   for (genvar k = 0; k < N_SRC; k++) begin : g_bit
      logic flag_q;

      // Set has priority over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= evt_i[k] | (flag_q & ~clr_i[k]);
      end

      assign stat_o[k] = flag_q;

      AST_SRC_SET:  assert property (@(posedge clk) disable iff (!rst_n)
                       evt_i[k] |=> stat_o[k]);                         // R4
      AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                       stat_o[k] && !clr_i[k] |=> stat_o[k]);           // R3
      AST_SRC_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
                       clr_i[k] && !evt_i[k] |=> !stat_o[k]);           // R3
   end

endmodule

// File: rtl/irqs_summary.sv
module irqs_summary #(
   parameter int N_SRC = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic [N_SRC-1:0] en_i,   // already restricted to this class
   input  logic             clr_i,
   output logic             sum_o
);

   logic hit;
   logic sum_q;

   assign hit = |(evt_i & en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= 1'b0;
      else        sum_q <= hit | (sum_q & ~clr_i);
   end

   assign sum_o = sum_q;

   AST_SUM_SET:  assert property (@(posedge clk) disable iff (!rst_n)
                    |(evt_i & en_i) |=> sum_o);                         // R5
   AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    sum_o && !clr_i |=> sum_o);                         // R6
   AST_SUM_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
                    clr_i && !(|(evt_i & en_i)) |=> !sum_o);            // R6

endmodule

// File: rtl/irqs_enable_reg.sv
module irqs_enable_reg #(
   parameter int              DATA_W = 32,
   parameter logic [DATA_W-1:0] MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] en_o
);

   // Only implemented positions get a flop; the rest are tied low
   for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      if (MASK[k]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    bit_q <= 1'b0;
            else if (wr_i) bit_q <= wdata_i[k];
         end
         assign en_o[k] = bit_q;
      end else begin : g_tie
         assign en_o[k] = 1'b0;
      end
   end

   AST_ENA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                     wr_i |=> en_o == ($past(wdata_i) & MASK));         // R7
   AST_ENA_KEEP:  assert property (@(posedge clk) disable iff (!rst_n)
                     !wr_i |=> $stable(en_o));                          // R7

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
   parameter int DATA_W      = 32,
   parameter int N_NORM      = 3,
   parameter int N_ABN       = 6,
   parameter int ABN_SUM_BIT = 15,
   parameter int NRM_SUM_BIT = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_NORM+N_ABN-1:0]   evt_i,
   input  logic                      bus_wr,
   input  logic                      bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   input  logic                      bus_raddr,
   output logic [DATA_W-1:0]         bus_rdata,
   output logic                      irq_o
);
   import irqs_pkg::*;

   localparam int N_SRC = N_NORM + N_ABN;
   localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] SRC_MASK = (ONE << N_SRC) - ONE;
   localparam logic [DATA_W-1:0] NRM_MASK = (ONE << N_NORM) - ONE;
   localparam logic [DATA_W-1:0] ABN_MASK = SRC_MASK & ~NRM_MASK;
   localparam logic [DATA_W-1:0] ENA_MASK = SRC_MASK | (ONE << ABN_SUM_BIT)
                                                     | (ONE << NRM_SUM_BIT);

   // Elaboration-time parameter checks
   if (N_NORM < 1 || N_ABN < 1) begin : g_chk_cnt
      $error("each class needs at least one source");
   end
   if (N_SRC > ABN_SUM_BIT || N_SRC > NRM_SUM_BIT) begin : g_chk_overlap
      $error("source bits overlap a summary position");
   end
   if (ABN_SUM_BIT == NRM_SUM_BIT) begin : g_chk_same
      $error("summary positions must differ");
   end
   if (ABN_SUM_BIT >= DATA_W || NRM_SUM_BIT >= DATA_W) begin : g_chk_width
      $error("summary position outside the data word");
   end

   logic              wr_stat, wr_ena;
   logic [N_SRC-1:0]  src_clr, src_stat, src_en;
   logic [DATA_W-1:0] ena_w, stat_w;
   logic [N_CLASS-1:0] sum_q, sum_en;

   assign wr_stat = bus_wr && (bus_addr == SEL_STATUS);
   assign wr_ena  = bus_wr && (bus_addr == SEL_ENABLE);
   assign src_clr = wr_stat ? bus_wdata[N_SRC-1:0] : '0;

   irqs_src_bank #(.N_SRC(N_SRC)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .clr_i  (src_clr),
      .stat_o (src_stat)
   );

   irqs_enable_reg #(.DATA_W(DATA_W), .MASK(ENA_MASK)) u_ena (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_ena),
      .wdata_i (bus_wdata),
      .en_o    (ena_w)
   );

   assign src_en = ena_w[N_SRC-1:0];

   // One summary per class: 0 normal, 1 abnormal
   for (genvar c = 0; c < N_CLASS; c++) begin : g_class
      localparam int               POS   = (c == 0) ? NRM_SUM_BIT : ABN_SUM_BIT;
      localparam logic [DATA_W-1:0] CMASK = (c == 0) ? NRM_MASK : ABN_MASK;
      logic [N_SRC-1:0] cls_en;

      assign cls_en    = src_en & CMASK[N_SRC-1:0];
      assign sum_en[c] = ena_w[POS];

      irqs_summary #(.N_SRC(N_SRC)) u_sum (
         .clk   (clk),
         .rst_n (rst_n),
         .evt_i (evt_i),
         .en_i  (cls_en),
         .clr_i (wr_stat && bus_wdata[POS]),
         .sum_o (sum_q[c])
      );

      AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
                        (|(evt_i & cls_en)) && sum_en[c] && !wr_ena
                        |=> irq_o);                                     // R8
   end

   always_comb begin
      stat_w              = '0;
      stat_w[N_SRC-1:0]   = src_stat;
      stat_w[NRM_SUM_BIT] = sum_q[0];
      stat_w[ABN_SUM_BIT] = sum_q[1];
   end

   assign bus_rdata = (bus_raddr == SEL_ENABLE) ? ena_w : stat_w;
   assign irq_o     = |(sum_q & sum_en);

   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                    !sum_en[0] && !sum_en[1] |-> !irq_o);               // R8

endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 9;
   localparam logic [31:0] NMASK = 32'h0000_0007;
   localparam logic [31:0] AMASK = 32'h0000_01F8;
   localparam logic [31:0] NSUM  = 32'h0001_0000;
   localparam logic [31:0] ASUM  = 32'h0000_8000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS-1:0] evt_i = '0;
   logic bus_wr = 1'b0;
   logic bus_addr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic bus_raddr = 1'b0;
   logic [31:0] bus_rdata;
   logic irq_o;

   int n_cmp = 0;
   int n_bad = 0;

   irq_status_ctrl uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_raddr(bus_raddr),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_evt(input logic a, input logic [31:0] d, input logic [NS-1:0] p);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_i = p;
      tick();
      bus_wr = 1'b0; bus_wdata = '0; evt_i = '0;
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      wr_evt(a, d, '0);
   endtask

   task automatic pulse(input logic [NS-1:0] p);
      evt_i = p;
      tick();
      evt_i = '0;
   endtask

   task automatic rd(input logic a, output logic [31:0] v);
      bus_raddr = a;
      #1;
      v = bus_rdata;
   endtask

   function automatic logic [31:0] sum_of(input logic [31:0] pat);
      return ((pat & NMASK) != 0 ? NSUM : 32'h0) | ((pat & AMASK) != 0 ? ASUM : 32'h0);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] exp;
      // R1: reset state
      repeat (3) tick();
      rd(1'b0, v); chk("R1 status", v, 32'h0);
      rd(1'b1, v); chk("R1 enable", v, 32'h0);
      chk("R1 irq", {31'h0, irq_o}, 32'h0);
      rst_n = 1'b1;
      tick();

      // R7: enable readback, undefined bits read 0
      wr(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, v); chk("R7 enable all", v, 32'h0001_81FF);
      wr(1'b1, 32'h0);
      rd(1'b1, v); chk("R7 enable none", v, 32'h0);

      // R2, R5, R6, R8, R10: each source with enable off and on
      for (int i = 0; i < NS; i++) begin
         for (int en = 0; en < 2; en++) begin
            logic [31:0] bit_i;
            logic [31:0] s;
            bit_i = 32'h1 << i;
            s = (en != 0) ? sum_of(bit_i) : 32'h0;
            wr(1'b0, 32'hFFFF_FFFF);
            wr(1'b1, ((en != 0) ? bit_i : 32'h0) | NSUM | ASUM);
            pulse(bit_i[NS-1:0]);
            rd(1'b0, v); chk("R2 R5 R10 source set", v, bit_i | s);
            chk("R8 irq after event", {31'h0, irq_o}, {31'h0, en[0]});
            wr(1'b0, bit_i);
            rd(1'b0, v); chk("R6 summary survives source clear", v, s);
            chk("R8 irq held", {31'h0, irq_o}, {31'h0, en[0]});
            wr(1'b0, NSUM | ASUM);
            rd(1'b0, v); chk("R6 summary cleared", v, 32'h0);
            chk("R8 irq dropped", {31'h0, irq_o}, 32'h0);
         end
      end

      // R3, R9: zero writes and undefined positions
      wr(1'b1, 32'h0);
      wr(1'b0, 32'hFFFF_FFFF);
      pulse(9'h1FF);
      wr(1'b0, 32'h0);
      rd(1'b0, v); chk("R3 zero write keeps", v, 32'h1FF);
      wr(1'b0, 32'h0000_00AA);
      rd(1'b0, v); chk("R3 partial clear", v, 32'h155);
      wr(1'b0, 32'hFFFE_7E00);
      rd(1'b0, v); chk("R9 undefined bits no effect", v, 32'h155);

      // R4: collision of event and clear on each bit
      wr(1'b1, 32'h0001_81FF);
      for (int i = 0; i < NS; i++) begin
         logic [31:0] bit_i;
         bit_i = 32'h1 << i;
         wr(1'b0, 32'hFFFF_FFFF);
         pulse(bit_i[NS-1:0]);
         wr_evt(1'b0, 32'hFFFF_FFFF, bit_i[NS-1:0]);
         rd(1'b0, v); chk("R4 set wins over clear", v, bit_i | sum_of(bit_i));
      end

      // R5, R10: sweep all event patterns with full enables
      for (int p = 1; p < 512; p++) begin
         wr(1'b0, 32'hFFFF_FFFF);
         pulse(p[NS-1:0]);
         exp = 32'(p) | sum_of(32'(p));
         rd(1'b0, v); chk("R5 R10 pattern sweep", v, exp);
         chk("R8 sweep irq", {31'h0, irq_o}, 32'h1);
      end

      // R8: summary enable gating
      wr(1'b0, 32'hFFFF_FFFF);
      wr(1'b1, 32'h0000_01FF);
      pulse(9'h001);
      rd(1'b0, v); chk("R5 normal summary set", v, 32'h0001_0001);
      chk("R8 irq gated off", {31'h0, irq_o}, 32'h0);
      wr(1'b1, 32'h0001_01FF);
      chk("R8 irq on enable", {31'h0, irq_o}, 32'h1);
      wr(1'b0, NSUM);
      chk("R8 irq after normal clear", {31'h0, irq_o}, 32'h0);
      wr(1'b1, 32'h0000_81FF);
      pulse(9'h008);
      chk("R8 irq abnormal", {31'h0, irq_o}, 32'h1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule